// File: doc/BRIEF.md
# Pre-Trigger Sample FIFO

This block buffers converter samples on their way to a host read port. The converter side pushes one 16-bit sample per conversion and flags the last sample of each scan. The host pops samples in arrival order. A read-data output always presents the oldest stored sample.

The block has a pre-trigger mode. Setup software first flushes the buffer. It then loads a threshold, given as a number of scans and a scan length, and arms the block. While the block waits for the trigger, the buffer keeps only the newest whole scans. When the first sample of a new scan arrives and the occupancy has already reached the threshold, the oldest complete scan is dropped in that same cycle. The trigger ends this dropping. From then on the buffer fills normally until it is full. Samples offered while full are lost and are recorded by a sticky overrun flag. Occupancy, empty, almost-full, full and an interrupt-request level are visible at the ports.

Top module: `pretrig_fifo`

## Requirements
- R1: After reset, `empty` is 1, `level` is 0, and `full`, `almost_full`, `overrun`, `irq` and `pretrig_active` are all 0.
- R2: Samples come out in the order they were accepted. Whenever `empty` is 0, `rd_data` shows the oldest stored sample. A pop happens only when `rd_en` is high and the buffer holds data. `rd_en` on an empty buffer changes nothing.
- R3: `empty` is 1 exactly when `level` is 0. `full` is 1 exactly when `level` equals DEPTH (1024). `almost_full` is 1 exactly when `level` is at least the loaded threshold.
- R4: A `cfg_load` pulse latches the scan length `cfg_len` and a threshold of `cfg_scans` × `cfg_len` samples. These take effect from the next cycle. The reset values are a threshold of DEPTH and a scan length of 1.
- R5: `pretrig_active` is set by `arm` and cleared by `trig` or `flush`. When more than one is high in a cycle, `flush` wins over `arm`, and `arm` wins over `trig`.
- R6: While `pretrig_active` is 1, a write that starts a scan, made when `level` is at least the threshold, removes the oldest `cfg_len` samples and stores the new one in the same cycle. The new level is the old level + 1 − scan length. A write starts a scan when it is the first write after reset or flush, or when the previous write had `wr_last` = 1.
- R7: While `pretrig_active` is 1, `rd_en` is ignored. The level and the data shown do not change because of it.
- R8: While `pretrig_active` is 0, nothing is discarded. A write made while `full` is lost and sets `overrun`. `overrun` stays set until a flush.
- R9: A `flush` pulse empties the buffer on the next cycle. It sets `empty` to 1 and clears `almost_full`, `full`, `overrun` and `pretrig_active`. The write on the same cycle is not stored.
- R10: `irq` is high when `overrun` is 1, or when `almost_full` is 1 and `pretrig_active` is 0.
- R11: A threshold equal to DEPTH is valid in pre-trigger mode. The buffer then stays full of the newest whole scans, and it drops a scan and stores a sample on the same cycle while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Converter presents a sample |
| wr_data | input | DW (16) | Sample value |
| wr_last | input | 1 | Sample is the last of its scan |
| rd_en | input | 1 | Host pops the oldest sample |
| rd_data | output | DW (16) | Oldest stored sample |
| flush | input | 1 | Empty the buffer and clear the flags |
| cfg_load | input | 1 | Latch threshold and scan length |
| cfg_scans | input | CW (11) | Threshold in scans |
| cfg_len | input | CW (11) | Samples per scan |
| arm | input | 1 | Enter pre-trigger mode |
| trig | input | 1 | Trigger event; leave pre-trigger mode |
| empty | output | 1 | No samples held |
| almost_full | output | 1 | Level at or above threshold |
| full | output | 1 | Level equals DEPTH |
| overrun | output | 1 | Sticky: a sample was lost while full |
| irq | output | 1 | Interrupt-request level |
| pretrig_active | output | 1 | Waiting for the trigger, discarding enabled |
| level | output | CW (11) | Samples currently held |

## Verification
The assertions assume a correct setup. The threshold is loaded only while the buffer is empty. Its product is between one scan and DEPTH. The converter writes whole scans of exactly the loaded length. Arming happens only when the level is at or below the threshold. The stimulus keeps to these rules. Every random round starts with a flush and then a configuration load. Scans are generated by a counter that raises `wr_last` on the last sample of the loaded length. `arm` is issued only right after the flush. Triggers and host reads are placed freely, including mid-scan and during the wait, to exercise the ignore and priority rules.

// File: rtl/pt_fifo_pkg.sv
// Shared types for the pre-trigger sample FIFO.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package pt_fifo_pkg;

    // One cycle's worth of pointer/count operations decided by the controller.
    typedef struct packed {
        logic flush;  // clear everything
        logic push;   // store the incoming sample
        logic pop;    // host removes the oldest sample
        logic drop;   // discard the oldest whole scan
    } fifo_op_t;

endpackage

// File: rtl/pt_fifo_ram.sv
// Sample storage: one write port, one asynchronous read port.
// Assumes: DEPTH is a power of two so addresses wrap naturally.
module pt_fifo_ram #(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store a sample at the write address.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the oldest sample to the host.
    assign rdata = mem[raddr];

endmodule

// File: rtl/pt_fifo_cfg.sv
// Threshold and scan-length registers. The scan count is converted
// to a sample threshold once, at load, so that no multiplier sits in
// the per-sample path.
// Assumes: loads happen while the buffer is empty. Out-of-range
// values are clamped: length to 1..DEPTH, threshold to len..DEPTH.
module pt_fifo_cfg #(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int PW   = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [CW-1:0] cfg_scans,
    input  logic [CW-1:0] cfg_len,
    output logic [CW-1:0] thr_samples,
    output logic [CW-1:0] scan_len
);

    logic [CW-1:0] len_eff;
    logic [PW-1:0] prod;
    logic [CW-1:0] thr_eff;

    // Clamp the scan length and form the sample threshold.
    always_comb begin
        if (cfg_len == '0) begin
            len_eff = CW'(1);
        end else if (cfg_len > CW'(DEPTH)) begin
            len_eff = CW'(DEPTH);
        end else begin
            len_eff = cfg_len;
        end
        prod = {{CW{1'b0}}, cfg_scans} * {{CW{1'b0}}, len_eff};
        if (prod > PW'(DEPTH)) begin
            thr_eff = CW'(DEPTH);
        end else if (prod < {{CW{1'b0}}, len_eff}) begin
            thr_eff = len_eff;
        end else begin
            thr_eff = prod[CW-1:0];
        end
    end

    // Hold the configuration between loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_samples <= CW'(DEPTH);
            scan_len    <= CW'(1);
        end else if (cfg_load) begin
            thr_samples <= thr_eff;
            scan_len    <= len_eff;
        end
    end

endmodule

// File: rtl/pt_fifo_ctrl.sv
// Decides each cycle's push/pop/drop. Tracks pre-trigger mode, the
// scan boundary and the sticky overrun flag.
// Assumes: the threshold is a whole number of scans, at most DEPTH,
// so in pre-trigger mode the buffer reaches it at a scan boundary.
module pt_fifo_ctrl
    import pt_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_last,
    input  logic          rd_en,
    input  logic          flush,
    input  logic          arm,
    input  logic          trig,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] thr_samples,
    input  logic [CW-1:0] scan_len,
    output fifo_op_t      op,
    output logic          waiting,
    output logic          overrun
);

    logic at_start;
    logic is_full;
    logic drop_ok;

    // Work out this cycle's storage operations.
    always_comb begin
        is_full  = (count == CW'(DEPTH));
        drop_ok  = waiting && wr_valid && at_start && !flush
                   && (count >= thr_samples) && (count >= scan_len);
        op.flush = flush;
        op.drop  = drop_ok;
        op.push  = wr_valid && !flush && (!is_full || drop_ok);
        op.pop   = rd_en && !flush && !waiting && (count != '0);
    end

    // Pre-trigger mode: flush beats arm, arm beats trig.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            waiting <= 1'b0;
        end else if (arm) begin
            waiting <= 1'b1;
        end else if (trig) begin
            waiting <= 1'b0;
        end
    end

    // Remember whether the next write opens a new scan.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            at_start <= 1'b1;
        end else if (wr_valid) begin
            at_start <= wr_last;
        end
    end

    // Sticky record of a sample lost to a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            overrun <= 1'b0;
        end else if (wr_valid && is_full && !drop_ok) begin
            overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/pt_fifo_ptrs.sv
// Read/write pointers and occupancy. A drop moves the read pointer
// by a whole scan. It may happen in the same cycle as a push.
// Assumes: pop and drop never occur together (the controller blocks
// pops in pre-trigger mode).
module pt_fifo_ptrs
    import pt_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_op_t      op,
    input  logic [CW-1:0] scan_len,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count
);

    logic [AW-1:0] rd_step;
    logic [CW-1:0] count_nxt;

    // Combine push, pop and drop into one occupancy update.
    always_comb begin
        rd_step   = (op.pop ? AW'(1) : '0) + (op.drop ? scan_len[AW-1:0] : '0);
        count_nxt = count + (op.push ? CW'(1) : '0)
                          - (op.pop  ? CW'(1) : '0)
                          - (op.drop ? scan_len : '0);
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + (op.push ? AW'(1) : '0);
            rd_ptr <= rd_ptr + rd_step;
            count  <= count_nxt;
        end
    end

endmodule

// File: rtl/pretrig_fifo.sv
// Top of the pre-trigger sample FIFO: converter write side, host
// read side, flags and interrupt level.
// Assumes: DEPTH is a power of two. The converter writes whole scans
// of the loaded length.
module pretrig_fifo
    import pt_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          flush,
    input  logic          cfg_load,
    input  logic [CW-1:0] cfg_scans,
    input  logic [CW-1:0] cfg_len,
    input  logic          arm,
    input  logic          trig,
    output logic          empty,
    output logic          almost_full,
    output logic          full,
    output logic          overrun,
    output logic          irq,
    output logic          pretrig_active,
    output logic [CW-1:0] level
);

    fifo_op_t      op;
    logic [CW-1:0] thr_samples;
    logic [CW-1:0] scan_len;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          waiting;

    pt_fifo_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_scans  (cfg_scans),
        .cfg_len    (cfg_len),
        .thr_samples(thr_samples),
        .scan_len   (scan_len)
    );

    pt_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_last    (wr_last),
        .rd_en      (rd_en),
        .flush      (flush),
        .arm        (arm),
        .trig       (trig),
        .count      (count),
        .thr_samples(thr_samples),
        .scan_len   (scan_len),
        .op         (op),
        .waiting    (waiting),
        .overrun    (overrun)
    );

    pt_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .scan_len(scan_len),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (count)
    );

    pt_fifo_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk  (clk),
        .we   (op.push),
        .waddr(wr_ptr),
        .wdata(wr_data),
        .raddr(rd_ptr),
        .rdata(rd_data)
    );

    // Status flags and interrupt level derived from occupancy and mode.
    always_comb begin
        level          = count;
        empty          = (count == '0);
        full           = (count == CW'(DEPTH));
        almost_full    = (count >= thr_samples);
        pretrig_active = waiting;
        irq            = overrun || (almost_full && !waiting);
    end

endmodule

// File: rtl/pt_fifo_checker.sv
// Temporal checks on the pre-trigger sample FIFO. Attached by bind.
// Assumes: the configuration is loaded only while empty, and arming
// happens only at or below the threshold.
module pt_fifo_checker #(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          wr_valid,
    input logic          empty,
    input logic          almost_full,
    input logic          full,
    input logic          overrun,
    input logic          pretrig_active,
    input logic [CW-1:0] level,
    input logic [CW-1:0] thr_samples
);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full && !almost_full && !overrun && !pretrig_active));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);

    assert_full_write_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && !pretrig_active && !flush) |=> overrun);

    assert_pretrig_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pretrig_active && (level <= thr_samples) && !flush) |=> (level <= thr_samples));

    assert_read_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pretrig_active && !wr_valid && !flush) |=> (level == $past(level)));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ({1'b0, level} <= {1'b0, $past(level)} + 1'b1));

endmodule

bind pretrig_fifo pt_fifo_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .wr_valid      (wr_valid),
    .empty         (empty),
    .almost_full   (almost_full),
    .full          (full),
    .overrun       (overrun),
    .pretrig_active(pretrig_active),
    .level         (level),
    .thr_samples   (thr_samples)
);

// File: tb/tb_pretrig_fifo.sv
module tb_pretrig_fifo;

    localparam int DEPTH = 1024;
    localparam int DW    = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_last = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          flush = 1'b0;
    logic          cfg_load = 1'b0;
    logic [CW-1:0] cfg_scans = '0;
    logic [CW-1:0] cfg_len = '0;
    logic          arm = 1'b0;
    logic          trig = 1'b0;
    logic          empty, almost_full, full, overrun, irq, pretrig_active;
    logic [CW-1:0] level;

    always #10 clk = ~clk;

    pretrig_fifo #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

    // reference state
    int q[$];
    bit m_wait, m_ovr, m_at;
    int m_thr, m_len;
    int seq;
    int checks, fails;
    bit done;

    task automatic ck(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_thr(input int s, input int l);
        int le = (l == 0) ? 1 : ((l > DEPTH) ? DEPTH : l);
        int p  = s * le;
        if (p > DEPTH) return DEPTH;
        if (p < le) return le;
        return p;
    endfunction

    task automatic compare();
        bit af = (q.size() >= m_thr);
        ck("R6", "level", int'(level), q.size());
        ck("R3", "empty", int'(empty), int'(q.size() == 0));
        ck("R3", "full", int'(full), int'(q.size() == DEPTH));
        ck("R3", "almost_full", int'(almost_full), int'(af));
        ck("R8", "overrun", int'(overrun), int'(m_ovr));
        ck("R10", "irq", int'(irq), int'(m_ovr || (af && !m_wait)));
        ck("R5", "pretrig_active", int'(pretrig_active), int'(m_wait));
        if (q.size() > 0) ck("R2", "rd_data", int'(rd_data), q[0]);
    endtask

    // One clock: drive at negedge, update model after posedge, compare at negedge.
    task automatic step(input bit wv, input bit wl, input bit rd, input bit fl,
                        input bit ar, input bit tg);
        int sz;
        bit drop;
        wr_valid = wv; wr_last = wl; wr_data = DW'(seq); rd_en = rd;
        flush = fl; arm = ar; trig = tg;
        @(posedge clk);
        #1;
        sz = q.size();
        if (fl) begin
            q.delete(); m_wait = 0; m_ovr = 0; m_at = 1;
        end else begin
            drop = m_wait && wv && m_at && sz >= m_thr && sz >= m_len;
            if (drop) repeat (m_len) void'(q.pop_front());
            else if (rd && sz > 0 && !m_wait) void'(q.pop_front());
            if (wv) begin
                if (sz < DEPTH || drop) q.push_back(seq & 16'hffff);
                else m_ovr = 1;
                m_at = wl;
            end
            if (ar) m_wait = 1;
            else if (tg) m_wait = 0;
        end
        if (wv) seq++;
        @(negedge clk);
        wr_valid = 0; wr_last = 0; rd_en = 0; flush = 0; arm = 0; trig = 0;
        compare();
    endtask

    task automatic configure(input int s, input int l);
        cfg_scans = CW'(s); cfg_len = CW'(l); cfg_load = 1;
        step(0, 0, 0, 0, 0, 0);
        cfg_load = 0;
        m_thr = exp_thr(s, l);
        m_len = (l == 0) ? 1 : ((l > DEPTH) ? DEPTH : l);
    endtask

    task automatic write_scan(input int rdpct);
        for (int i = 0; i < m_len; i++)
            step(1, i == m_len - 1, $urandom_range(0, 99) < rdpct, 0, 0, 0);
    endtask

    initial begin
        int lv;
        void'($urandom(32'h5eed_1234));
        m_thr = DEPTH; m_len = 1; m_at = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        ck("R1", "empty", int'(empty), 1);
        ck("R1", "level", int'(level), 0);
        ck("R1", "flags", int'({full, almost_full, overrun, irq, pretrig_active}), 0);

        // R4: threshold = 2 scans x 3 samples
        configure(2, 3);
        repeat (5) step(1, 0, 0, 0, 0, 0);
        ck("R4", "almost_full at 5", int'(almost_full), 0);
        step(1, 1, 0, 0, 0, 0);
        ck("R4", "almost_full at 6", int'(almost_full), 1);
        while (q.size() > 0) step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        ck("R2", "read on empty", int'(level), 0);

        // R6/R7: pre-trigger keeps the newest two scans
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        for (int s = 0; s < 4; s++) write_scan(0);
        ck("R6", "level held at threshold", int'(level), 6);
        ck("R6", "oldest kept sample", int'(rd_data), seq - 6);
        lv = int'(level);
        step(0, 0, 1, 0, 0, 0);
        ck("R7", "read ignored while waiting", int'(level), lv);
        step(0, 0, 0, 0, 0, 1);
        write_scan(0);
        ck("R8", "no discard after trigger", int'(level), 9);
        while (q.size() > 0) step(0, 0, 1, 0, 0, 0);

        // R8/R10: overrun in normal mode
        step(0, 0, 0, 1, 0, 0);
        configure(256, 4);
        for (int i = 0; i < DEPTH + 1; i++) step(1, (i % 4) == 3, 0, 0, 0, 0);
        ck("R8", "overrun after full write", int'(overrun), 1);
        ck("R10", "irq on overrun", int'(irq), 1);
        step(0, 0, 0, 1, 0, 0);
        // R9 flush
        ck("R9", "flush clears", int'({empty, almost_full, full, overrun, pretrig_active}), 5'b10000);

        // R11: threshold equal to DEPTH in pre-trigger mode
        step(0, 0, 0, 0, 1, 0);
        for (int s = 0; s < 257; s++) write_scan(0);
        ck("R11", "full of newest scans", int'(level), DEPTH);
        ck("R11", "oldest after drop", int'(rd_data), (seq - DEPTH) & 16'hffff);
        ck("R11", "no overrun while dropping", int'(overrun), 0);

        // random rounds
        for (int r = 0; r < 12; r++) begin
            int l = $urandom_range(1, 8);
            int s = $urandom_range(1, 12);
            int ns = $urandom_range(2, 30);
            int tpos = $urandom_range(0, ns * l);
            bit armed = $urandom_range(0, 1);
            int n = 0;
            step(0, 0, 0, 1, 0, 0);
            configure(s, l);
            if (armed) step(0, 0, 0, 0, 1, 0);
            for (int k = 0; k < ns; k++)
                for (int i = 0; i < l; i++) begin
                    step(1, i == l - 1, $urandom_range(0, 1), 0, 0, n == tpos);
                    n++;
                    if ($urandom_range(0, 3) == 0) step(0, 0, $urandom_range(0, 1), 0, 0, 0);
                end
            step(0, 0, 0, 0, 0, 1);
            while (q.size() > 0) step(0, 0, 1, 0, 0, 0);
        end

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule